// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 device from power-on to a usable state. It steps through a fixed, computed list of steps. Each step is either a one-cycle memory command or a wait of a set number of clocks. Every step also fixes the levels of the memory reset, clock-enable and on-die-termination pins. When the last wait has run out, the block raises a done flag and parks the command pins on NOP.

The order is as follows. Reset is held and then released, after which clock-enable rises. The four mode registers are then written, MR2 first, then MR3, MR1 and MR0, with a short gap after each. A long ZQ calibration follows, then a precharge of all banks and a single auto-refresh. Every interval is a parameter in clocks. This allows the block to be retargeted to another clock rate, and allows a bench to shrink the long reset delays.

All outputs are registered. Asserting the active-low reset at any point returns the pins to their power-on levels and restarts the list from the first step.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While `rst_ni` is low, the outputs are `mem_rst_no`=0, `mem_cke_o`=0, `mem_odt_o`=0, `mem_cmd_o`=NOP (4'b0111), `mem_ba_o`=0, `mem_addr_o`=0 and `init_done_o`=0.
- R2: After reset is released, `mem_rst_no` stays low for exactly `T_RST` cycles and then goes high, while `mem_cke_o` is still low.
- R3: `mem_cke_o` rises exactly `T_CKE` cycles after `mem_rst_no` rises, and it is never high while `mem_rst_no` is low.
- R4: The first command appears exactly `T_XPR` cycles after `mem_cke_o` rises. By default `T_XPR` is `T_RFC`+7.
- R5: The command pins are ordered {cs_n, ras_n, cas_n, we_n} (bit 3 = cs_n). Mode-register writes (4'b0000) go to MR2, MR3, MR1 and MR0, in that order. Each write carries the register index on `mem_ba_o` and the matching `MRx_VAL` on `mem_addr_o`. Successive writes are issued `T_MRD`+1 cycles apart.
- R6: ZQ calibration (4'b0110) with `mem_addr_o` bit 10 set and `mem_ba_o`=0 is issued `T_MOD`+1 cycles after the MR0 write.
- R7: Precharge (4'b0010) with `mem_addr_o` bit 10 set is issued `T_ZQ`+1 cycles after the ZQ calibration command.
- R8: Refresh (4'b0001) is issued `T_RP`+1 cycles after the precharge.
- R9: `init_done_o` rises `T_RFC`+1 cycles after the refresh. From then on it stays high, with NOP on the command pins and both `mem_rst_no` and `mem_cke_o` high.
- R10: Each command lasts one cycle, and no two commands are adjacent. Every other cycle carries NOP (4'b0111), which makes seven commands in the whole sequence.
- R11: `mem_odt_o` stays low for the whole sequence and after done.
- R12: If `rst_ni` is asserted mid-sequence, the pins immediately take the R1 levels. After release, the whole sequence runs again with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; restarts the sequence |
| mem_rst_no | output | 1 | Memory reset, active low |
| mem_cke_o | output | 1 | Memory clock enable |
| mem_odt_o | output | 1 | On-die termination control |
| mem_cmd_o | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| mem_ba_o | output | 3 | Bank address (mode-register index for MRS) |
| mem_addr_o | output | 14 | Row/address pins (mode-register value for MRS) |
| init_done_o | output | 1 | Sequence complete |

## Verification
The bench builds the block with `T_RST`=40 and `T_CKE`=100 in place of the tens of thousands of clocks used in hardware. It sets `T_RFC`=20 and leaves `T_XPR` at its derived value of 27, which exercises the default derivation. `T_ZQ` keeps its real value of 512. With these values a complete power-up takes under a thousand cycles. That makes it practical to measure every gap between edges to the exact cycle, to run the whole sequence twice, and to restart it partway between two mode-register writes. Distinct values for each mode register show that the index and the value travel together on the bank and address pins.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

  localparam int ADDR_W  = 14;
  localparam int BA_W    = 3;
  localparam int N_STEPS = 18;
  localparam int IDX_W   = $clog2(N_STEPS);

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_ZQC = 4'b0110,
    CMD_NOP = 4'b0111
  } ddr_cmd_e;

  typedef struct packed {
    logic              last;
    logic              timed;
    logic              rst_n;
    logic              cke;
    logic              odt;
    ddr_cmd_e          cmd;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
  } init_step_t;

  localparam logic [ADDR_W-1:0] A10 = ADDR_W'(1) << 10;

endpackage

// File: rtl/ddr3_init_rom.sv
module ddr3_init_rom
  import ddr3_init_pkg::*;
#(
  parameter int CNT_W  = 17,
  parameter int T_RST  = 40000,
  parameter int T_CKE  = 100000,
  parameter int T_XPR  = 327,
  parameter int T_MRD  = 4,
  parameter int T_MOD  = 12,
  parameter int T_ZQ   = 512,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 320,
  parameter logic [ADDR_W-1:0] MR0_VAL = '0,
  parameter logic [ADDR_W-1:0] MR1_VAL = '0,
  parameter logic [ADDR_W-1:0] MR2_VAL = '0,
  parameter logic [ADDR_W-1:0] MR3_VAL = '0
) (
  input  logic [IDX_W-1:0] idx_i,
  output init_step_t       step_o,
  output logic [CNT_W-1:0] len_o
);

  function automatic init_step_t mk_wait(logic rn, logic ck);
    init_step_t s;
    s       = '0;
    s.timed = 1'b1;
    s.rst_n = rn;
    s.cke   = ck;
    s.cmd   = CMD_NOP;
    return s;
  endfunction

  function automatic init_step_t mk_cmd(ddr_cmd_e c, logic [BA_W-1:0] b,
                                        logic [ADDR_W-1:0] a);
    init_step_t s;
    s       = '0;
    s.rst_n = 1'b1;
    s.cke   = 1'b1;
    s.cmd   = c;
    s.ba    = b;
    s.addr  = a;
    return s;
  endfunction

  always_comb begin
    len_o = '0;
    unique case (idx_i)
      5'd0:  begin step_o = mk_wait(1'b0, 1'b0); len_o = CNT_W'(T_RST); end
      5'd1:  begin step_o = mk_wait(1'b1, 1'b0); len_o = CNT_W'(T_CKE); end
      5'd2:  begin step_o = mk_wait(1'b1, 1'b1); len_o = CNT_W'(T_XPR); end
      5'd3:  step_o = mk_cmd(CMD_MRS, BA_W'(2), MR2_VAL);
      5'd4:  begin step_o = mk_wait(1'b1, 1'b1); len_o = CNT_W'(T_MRD); end
      5'd5:  step_o = mk_cmd(CMD_MRS, BA_W'(3), MR3_VAL);
      5'd6:  begin step_o = mk_wait(1'b1, 1'b1); len_o = CNT_W'(T_MRD); end
      5'd7:  step_o = mk_cmd(CMD_MRS, BA_W'(1), MR1_VAL);
      5'd8:  begin step_o = mk_wait(1'b1, 1'b1); len_o = CNT_W'(T_MRD); end
      5'd9:  step_o = mk_cmd(CMD_MRS, BA_W'(0), MR0_VAL);
      5'd10: begin step_o = mk_wait(1'b1, 1'b1); len_o = CNT_W'(T_MOD); end
      5'd11: step_o = mk_cmd(CMD_ZQC, '0, A10);
      5'd12: begin step_o = mk_wait(1'b1, 1'b1); len_o = CNT_W'(T_ZQ); end
      5'd13: step_o = mk_cmd(CMD_PRE, '0, A10);
      5'd14: begin step_o = mk_wait(1'b1, 1'b1); len_o = CNT_W'(T_RP); end
      5'd15: step_o = mk_cmd(CMD_REF, '0, '0);
      5'd16: begin step_o = mk_wait(1'b1, 1'b1); len_o = CNT_W'(T_RFC); end
      default: begin
        step_o      = mk_cmd(CMD_NOP, '0, '0);
        step_o.last = 1'b1;
      end
    endcase
  end

  // a zero-length wait would underflow the timer
  always_comb
    AST_WAIT_NONZERO: assert (!step_o.timed || len_o != '0); // R2

endmodule

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int CNT_W   = 17,
  parameter int RST_LEN = 40000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= CNT_W'(RST_LEN - 1);
    else if (load_i)          cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

  AST_LOAD_ON_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> zero_o); // R4

endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
  import ddr3_init_pkg::*;
#(
  parameter int T_RST  = 40000,
  parameter int T_CKE  = 100000,
  parameter int T_RFC  = 320,
  parameter int T_XPR  = T_RFC + 7,
  parameter int T_MRD  = 4,
  parameter int T_MOD  = 12,
  parameter int T_ZQ   = 512,
  parameter int T_RP   = 3,
  parameter logic [13:0] MR0_VAL = 14'h0124,
  parameter logic [13:0] MR1_VAL = 14'h0047,
  parameter logic [13:0] MR2_VAL = 14'h0008,
  parameter logic [13:0] MR3_VAL = 14'h0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        mem_rst_no,
  output logic        mem_cke_o,
  output logic        mem_odt_o,
  output logic [3:0]  mem_cmd_o,
  output logic [2:0]  mem_ba_o,
  output logic [13:0] mem_addr_o,
  output logic        init_done_o
);

  localparam int T_M1  = (T_RST > T_CKE) ? T_RST : T_CKE;
  localparam int T_M2  = (T_XPR > T_RFC) ? T_XPR : T_RFC;
  localparam int T_M3  = (T_ZQ  > T_MOD) ? T_ZQ  : T_MOD;
  localparam int T_M4  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_M5  = (T_M3 > T_M4) ? T_M3 : T_M4;
  localparam int T_MAX = (T_M5 > T_MRD + T_RP) ? T_M5 : T_MRD + T_RP;
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic [IDX_W-1:0] idx_q;
  init_step_t       step;
  logic [CNT_W-1:0] step_len;
  logic             tmr_zero;
  logic             step_adv;

  ddr3_init_rom #(
    .CNT_W(CNT_W), .T_RST(T_RST), .T_CKE(T_CKE), .T_XPR(T_XPR),
    .T_MRD(T_MRD), .T_MOD(T_MOD), .T_ZQ(T_ZQ), .T_RP(T_RP), .T_RFC(T_RFC),
    .MR0_VAL(MR0_VAL), .MR1_VAL(MR1_VAL), .MR2_VAL(MR2_VAL), .MR3_VAL(MR3_VAL)
  ) u_rom (
    .idx_i  (idx_q),
    .step_o (step),
    .len_o  (step_len)
  );

  // step 0 is preloaded by reset, so the timer starts on its length
  ddr3_init_timer #(.CNT_W(CNT_W), .RST_LEN(T_RST)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (step_adv && step.timed),
    .len_i  (step_len),
    .zero_o (tmr_zero)
  );

  assign step_adv = tmr_zero && !init_done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= IDX_W'(1);
      mem_rst_no  <= 1'b0;
      mem_cke_o   <= 1'b0;
      mem_odt_o   <= 1'b0;
      mem_cmd_o   <= CMD_NOP;
      mem_ba_o    <= '0;
      mem_addr_o  <= '0;
      init_done_o <= 1'b0;
    end else if (step_adv) begin
      mem_rst_no  <= step.rst_n;
      mem_cke_o   <= step.cke;
      mem_odt_o   <= step.odt;
      mem_cmd_o   <= step.timed ? CMD_NOP : step.cmd;
      mem_ba_o    <= step.timed ? '0 : step.ba;
      mem_addr_o  <= step.timed ? '0 : step.addr;
      init_done_o <= step.last;
      if (!step.last) idx_q <= idx_q + IDX_W'(1);
    end else begin
      mem_cmd_o   <= CMD_NOP;
      mem_ba_o    <= '0;
      mem_addr_o  <= '0;
    end
  end

  AST_WAIT_IS_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_zero |-> mem_cmd_o == CMD_NOP); // R10
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cmd_o != CMD_NOP |=> mem_cmd_o == CMD_NOP); // R10
  AST_ODT_LOW_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rst_no |-> !mem_odt_o); // R11
  AST_CKE_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cke_o |-> mem_rst_no); // R3
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o); // R9
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (mem_cmd_o == CMD_NOP && mem_cke_o && mem_rst_no)); // R9

endmodule

// File: tb/tb_ddr3_pwrup_seq.sv
`timescale 1ns/1ps
module tb_ddr3_pwrup_seq;

  localparam int T_RST = 40;
  localparam int T_CKE = 100;
  localparam int T_RFC = 20;
  localparam int T_XPR = T_RFC + 7;
  localparam int T_MRD = 4;
  localparam int T_MOD = 12;
  localparam int T_ZQ  = 512;
  localparam int T_RP  = 3;
  localparam logic [13:0] MR0 = 14'h0520;
  localparam logic [13:0] MR1 = 14'h0046;
  localparam logic [13:0] MR2 = 14'h0018;
  localparam logic [13:0] MR3 = 14'h0004;
  localparam int NOP = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_rst_n, cke, odt, done;
  logic [3:0]  cmd;
  logic [2:0]  ba;
  logic [13:0] addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ddr3_pwrup_seq #(
    .T_RST(T_RST), .T_CKE(T_CKE), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .T_MOD(T_MOD), .T_ZQ(T_ZQ), .T_RP(T_RP),
    .MR0_VAL(MR0), .MR1_VAL(MR1), .MR2_VAL(MR2), .MR3_VAL(MR3)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_rst_no(mem_rst_n), .mem_cke_o(cke),
    .mem_odt_o(odt), .mem_cmd_o(cmd), .mem_ba_o(ba), .mem_addr_o(addr),
    .init_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(mem_rst_n == 1'b0, req, "mem_rst_no", int'(mem_rst_n), 0);
    chk(cke == 1'b0,       req, "cke",        int'(cke), 0);
    chk(odt == 1'b0,       req, "odt",        int'(odt), 0);
    chk(int'(cmd) == NOP,  req, "cmd",        int'(cmd), NOP);
    chk(ba == 3'd0 && addr == 14'd0, req, "ba/addr", int'({ba, addr}), 0);
    chk(done == 1'b0,      req, "done",       int'(done), 0);
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
  endtask

  // starts right after reset release at a negedge
  task automatic test_full_run(input string tag);
    int cyc = 0;
    int t_rst = -1, t_cke = -1, t_done = -1, ncmd = 0;
    int ct[8], cc[8], cb[8], ca[8];
    bit prev_cmd = 0, b2b = 0, odt_hi = 0, cke_early = 0;
    int e0, e_zq, e_pre, e_ref, e_done;
    while (t_done < 0 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (mem_rst_n && t_rst < 0) t_rst = cyc;
      if (cke && t_cke < 0) t_cke = cyc;
      if (cke && !mem_rst_n) cke_early = 1;
      if (odt) odt_hi = 1;
      if (int'(cmd) != NOP) begin
        if (ncmd < 8) begin
          ct[ncmd] = cyc; cc[ncmd] = int'(cmd);
          cb[ncmd] = int'(ba); ca[ncmd] = int'(addr);
        end
        ncmd++;
        if (prev_cmd) b2b = 1;
        prev_cmd = 1;
      end else prev_cmd = 0;
      if (done && t_done < 0) t_done = cyc;
    end
    e0     = T_RST + T_CKE + T_XPR;
    e_zq   = e0 + 3 * (T_MRD + 1) + T_MOD + 1;
    e_pre  = e_zq + T_ZQ + 1;
    e_ref  = e_pre + T_RP + 1;
    e_done = e_ref + T_RFC + 1;
    $display("run %s", tag);
    chk(t_rst == T_RST, "R2", "reset release cycle", t_rst, T_RST);
    chk(t_cke - t_rst == T_CKE, "R3", "cke delay", t_cke - t_rst, T_CKE);
    chk(!cke_early, "R3", "cke high in reset", int'(cke_early), 0);
    chk(ncmd == 7, "R10", "command count", ncmd, 7);
    chk(!b2b, "R10", "adjacent commands", int'(b2b), 0);
    if (ncmd == 7) begin
      chk(ct[0] - t_cke == T_XPR, "R4", "first cmd after cke", ct[0] - t_cke, T_XPR);
      for (int k = 0; k < 4; k++) begin
        int ei;
        int ea;
        ei = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 1 : 0;
        ea = (k == 0) ? int'(MR2) : (k == 1) ? int'(MR3) : (k == 2) ? int'(MR1) : int'(MR0);
        chk(cc[k] == 0, "R5", "mrs opcode", cc[k], 0);
        chk(cb[k] == ei, "R5", "mrs index", cb[k], ei);
        chk(ca[k] == ea, "R5", "mrs value", ca[k], ea);
        chk(ct[k] == e0 + k * (T_MRD + 1), "R5", "mrs time", ct[k], e0 + k * (T_MRD + 1));
      end
      chk(cc[4] == 6 && cb[4] == 0, "R6", "zq opcode/ba", cc[4] * 8 + cb[4], 48);
      chk(ca[4] == 1024, "R6", "zq a10", ca[4], 1024);
      chk(ct[4] == e_zq, "R6", "zq time", ct[4], e_zq);
      chk(cc[5] == 2 && ca[5] == 1024, "R7", "precharge-all", cc[5] * 2048 + ca[5], 2 * 2048 + 1024);
      chk(ct[5] == e_pre, "R7", "precharge time", ct[5], e_pre);
      chk(cc[6] == 1, "R8", "refresh opcode", cc[6], 1);
      chk(ct[6] == e_ref, "R8", "refresh time", ct[6], e_ref);
    end
    chk(t_done == e_done, "R9", "done time", t_done, e_done);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (odt) odt_hi = 1;
      if (!(done && int'(cmd) == NOP && cke && mem_rst_n)) begin
        chk(1'b0, "R9", "post-done state", int'({done, cmd, cke, mem_rst_n}), 'b1011111);
        break;
      end
    end
    chk(done == 1'b1, "R9", "done held", int'(done), 1);
    chk(!odt_hi, "R11", "odt raised", int'(odt_hi), 0);
  endtask

  task automatic test_restart();
    int stop_at;
    stop_at = T_RST + T_CKE + T_XPR + 2;  // between MR2 and MR3
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (stop_at) @(negedge clk);
    chk(cke == 1'b1 && mem_rst_n == 1'b1, "R12", "mid-run state", int'({cke, mem_rst_n}), 3);
    rst_n = 1'b0;
    #1;
    check_idle("R12");
    @(negedge clk);
    check_idle("R12");
    rst_n = 1'b1;
    test_full_run("restart R12");
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    test_reset_state();
    test_full_run("first");
    test_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule